// File: doc/BRIEF.md
# Bidirectional Inverting Latched Transceiver

This block moves a data word between two ports, A and B, in either direction. Each direction has its own bank of latches that can be made transparent or made to hold. Each direction also has its own set of three active-low controls: a bank enable, a latch enable and a drive enable. The word is inverted on the way through in both directions.

The design is synthesizable, so it has no inout wires. Each port has a data-in vector, a data-out vector and a single drive-enable bit. The level above resolves the tri-state net from these. The latch banks are emulated with a clock:

- While a bank is transparent, its output follows the inverted input within the same cycle.
- While a bank is transparent, its storage register takes the input at every rising clock edge.
- When the bank stops being transparent, it keeps the value taken at the last edge.

The two directions share nothing except the clock and reset. Nothing arbitrates between them when both ports drive at once.

Top module: `inv_latch_xcvr`

## Requirements
- R1: The A-to-B bank and the B-to-A bank are independent. The controls and data of one direction never change the output, drive bit or stored word of the other direction.
- R2: The data word is bitwise inverted in both directions. `b_out` carries the complement of the A-to-B bank view, and `a_out` carries the complement of the B-to-A bank view.
- R3: A bank is transparent when its bank enable and its latch enable are both low. Its output port then shows the complement of its input port in the same cycle.
- R4: With the bank enable low, after the latch enable goes high the output keeps the complement of the word captured at the last clock edge. Later input changes have no effect on it.
- R5: With the bank enable high, the bank holds its word whatever the latch enable and the input do.
- R6: A port's drive bit (`b_oe` for A-to-B, `a_oe` for B-to-A) is 1 only when that direction's bank enable and drive enable are both low. Otherwise it is 0, meaning high impedance.
- R7: An active-low reset clears both stored words to zero. After reset, a bank that is not transparent shows all ones on its output port.
- R8: The output vector carries the bank view whether or not the drive bit is set, so a held word can be observed before it is driven.
- R9: The storage register of a transparent bank takes the input present at each rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the latch storage |
| rst_n | input | 1 | Active-low reset that clears both banks |
| a_in | input | WIDTH | Data arriving on port A (A-to-B source) |
| a_out | output | WIDTH | Inverted B-to-A bank view for port A |
| a_oe | output | 1 | 1 when port A should actively drive `a_out` |
| b_in | input | WIDTH | Data arriving on port B (B-to-A source) |
| b_out | output | WIDTH | Inverted A-to-B bank view for port B |
| b_oe | output | 1 | 1 when port B should actively drive `b_out` |
| ab_cen | input | 1 | A-to-B bank enable, active low |
| ab_len | input | 1 | A-to-B latch enable, active low |
| ab_oen | input | 1 | A-to-B drive enable, active low |
| ba_cen | input | 1 | B-to-A bank enable, active low |
| ba_len | input | 1 | B-to-A latch enable, active low |
| ba_oen | input | 1 | B-to-A drive enable, active low |

## Verification
The assertions check the following on every cycle:

- A bank that is not transparent keeps its storage and output steady.
- A transparent bank stores the word seen at the edge.
- A disabled bank never sets its drive bit.

The bench's scenarios cover the rest. These include the complement relation between ports, isolation between the two directions, the value left after reset, and the observation of a held word both before and after it is driven. Random stimulus then covers every control combination in both directions, and the bench reports cycles where both ports drive at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Decoded per-direction control.
    typedef struct packed {
        logic pass;   // bank is transparent
        logic drive;  // output port actively drives
    } dir_ctrl_t;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_AB   = 0;
    localparam int unsigned DIR_BA   = 1;

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cen_n,
    input  logic      len_n,
    input  logic      oen_n,
    output dir_ctrl_t ctrl
);

    always_comb begin
        ctrl       = '0;
        ctrl.pass  = !cen_n && !len_n;
        ctrl.drive = !cen_n && !oen_n;
    end

    // R6: a disabled bank never drives its port.
    p_no_drive_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |-> !ctrl.drive);

    // R5: a disabled bank is never transparent.
    p_no_pass_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |-> !ctrl.pass);

endmodule

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] view_inv
);

    typedef struct packed {
        logic [WIDTH-1:0] held;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pass) begin
            st_d.held = din;
        end
        view_inv = pass ? ~din : ~st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a transparent bank stores the input present at the edge.
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (st_q.held == $past(din)));

    // R4: an opaque bank keeps its word.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |=> $stable(st_q.held));

    // R4: output stays steady over consecutive opaque cycles.
    p_view_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && $past(!pass)) |-> $stable(view_inv));

endmodule

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_cen,
    input  logic             ab_len,
    input  logic             ab_oen,
    input  logic             ba_cen,
    input  logic             ba_len,
    input  logic             ba_oen
);

    logic [NUM_DIRS-1:0]            cen_v, len_v, oen_v;
    logic [NUM_DIRS-1:0][WIDTH-1:0] src_v, view_v;
    dir_ctrl_t                      ctrl_v [NUM_DIRS];

    assign cen_v[DIR_AB] = ab_cen;
    assign len_v[DIR_AB] = ab_len;
    assign oen_v[DIR_AB] = ab_oen;
    assign src_v[DIR_AB] = a_in;
    assign cen_v[DIR_BA] = ba_cen;
    assign len_v[DIR_BA] = ba_len;
    assign oen_v[DIR_BA] = ba_oen;
    assign src_v[DIR_BA] = b_in;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        xcvr_dir_ctrl u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .cen_n (cen_v[g]),
            .len_n (len_v[g]),
            .oen_n (oen_v[g]),
            .ctrl  (ctrl_v[g])
        );

        xcvr_dir_store #(.WIDTH(WIDTH)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .pass     (ctrl_v[g].pass),
            .din      (src_v[g]),
            .view_inv (view_v[g])
        );
    end

    assign b_out = view_v[DIR_AB];
    assign b_oe  = ctrl_v[DIR_AB].drive;
    assign a_out = view_v[DIR_BA];
    assign a_oe  = ctrl_v[DIR_BA].drive;

    // R6: port drive bits follow the direction's bank enable.
    p_b_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ab_cen |-> !b_oe);
    p_a_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ba_cen |-> !a_oe);

    // R1: the A-to-B output is unaffected by B-to-A activity while opaque.
    p_ab_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_cen && $past(ab_cen)) |-> $stable(b_out));

endmodule

// File: tb/inv_latch_xcvr_bench.sv
module inv_latch_xcvr_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic ab_cen = 1'b1, ab_len = 1'b1, ab_oen = 1'b1;
    logic ba_cen = 1'b1, ba_len = 1'b1, ba_oen = 1'b1;

    int errors = 0;
    int checks = 0;
    int contention = 0;
    logic [W-1:0] m_ab, m_ba;   // model storage per direction

    always #2.5 clk = ~clk;   // 200 MHz

    inv_latch_xcvr #(.WIDTH(W)) u_inv_latch_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_cen(ab_cen), .ab_len(ab_len), .ab_oen(ab_oen),
        .ba_cen(ba_cen), .ba_len(ba_len), .ba_oen(ba_oen)
    );

    function automatic logic [W-1:0] exp_view(logic cen, logic len,
                                              logic [W-1:0] din, logic [W-1:0] held);
        return (!cen && !len) ? ~din : ~held;
    endfunction

    function automatic logic exp_drive(logic cen, logic oen);
        return !cen && !oen;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check shortly after, then advance model as the next posedge will.
    task automatic step(logic [W-1:0] ai, logic [W-1:0] bi,
                        logic [2:0] abc, logic [2:0] bac, string tag);
        @(negedge clk);
        a_in = ai; b_in = bi;
        {ab_cen, ab_len, ab_oen} = abc;
        {ba_cen, ba_len, ba_oen} = bac;
        #1;
        chk({tag, " R2 R3 R4 R5 R8 b_out"}, b_out, exp_view(ab_cen, ab_len, a_in, m_ab));
        chk({tag, " R2 R3 R4 R5 R8 a_out"}, a_out, exp_view(ba_cen, ba_len, b_in, m_ba));
        chk({tag, " R6 b_oe"}, W'(b_oe), W'(exp_drive(ab_cen, ab_oen)));
        chk({tag, " R6 a_oe"}, W'(a_oe), W'(exp_drive(ba_cen, ba_oen)));
        if (a_oe && b_oe) contention++;
        if (!ab_cen && !ab_len) m_ab = a_in;   // R9
        if (!ba_cen && !ba_len) m_ba = b_in;
    endtask

    initial begin
        #(5 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] seed_dummy;
        seed_dummy = W'($urandom(32'd4242));
        m_ab = '0; m_ba = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R7: reset leaves both banks zero, outputs all ones, no drive.
        chk("R7 reset b_out", b_out, '1);
        chk("R7 reset a_out", a_out, '1);
        chk("R7 reset drive", W'({a_oe, b_oe}), '0);

        // R3/R9: load A-to-B transparently, not driving yet (R8).
        step(8'h3C, 8'h00, 3'b001, 3'b111, "load_ab");
        step(8'h5A, 8'h00, 3'b001, 3'b111, "follow_ab");
        // R4: raise latch enable, change input: held word persists.
        step(8'hFF, 8'h00, 3'b011, 3'b111, "hold_ab");
        step(8'h00, 8'h00, 3'b010, 3'b111, "hold_drive_ab");
        chk("R4 held word driven", b_out, ~8'h5A);
        // R5: bank disabled, latch enable low: still holds, no drive.
        step(8'h81, 8'h00, 3'b100, 3'b111, "cen_high_ab");
        chk("R5 disabled hold", b_out, ~8'h5A);
        chk("R6 disabled no drive", W'(b_oe), '0);
        // R1: B-to-A activity leaves the A-to-B side untouched.
        step(8'h81, 8'hC3, 3'b110, 3'b000, "load_ba");
        chk("R1 ab isolated", b_out, ~8'h5A);
        chk("R2 ba inverted", a_out, ~8'hC3);
        step(8'h81, 8'h11, 3'b110, 3'b010, "hold_ba");
        chk("R4 ba held", a_out, ~8'hC3);

        for (int i = 0; i < 2000; i++) begin
            step(W'($urandom), W'($urandom), 3'($urandom), 3'($urandom), "random");
        end

        $display("Info: cycles with both ports driving: %0d", contention);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule